// File: doc/BRIEF.md
# Triple-Thread Result Voter

This block is the last stage of a pipeline shared by three hardware threads that run the same program. The threads issue one cycle apart, in a fixed order: thread 2 first, then thread 1, then thread 0. Each result, whether a register write or a load/store request, arrives tagged with its thread number. Results from threads 2 and 1 go into a buffer register owned by each thread. When the matching result from thread 0 arrives, the block votes the three copies bit by bit.

One cycle after the vote it issues at most one register-file write and at most one memory request, both built from the voted fields. A memory location or peripheral is therefore touched once per instruction, not three times. Status pulses report three things: a copy that disagreed, three destinations that all differ, and a thread that overwrote its own unvoted buffer.

Top module: `tmr_wb_voter`

## Requirements
- R1: While reset is held and in the first cycle after it, rf_we, mem_req, vote_mismatch, vote_dest_split and buf_overrun are all 0.
- R2: A result tagged thread 2 (in_tid=2) or thread 1 (in_tid=1) only fills that thread's buffer. It produces no rf_we or mem_req in the following cycle.
- R3: A result tagged thread 0 (in_tid=0) causes, in the next cycle, a one-cycle pulse on rf_we equal to the majority of the three write-enable copies. On the same cycle rf_addr and rf_data carry the bitwise 2-of-3 majority of the three destinations and data words. The three copies are the thread 2 buffer, the thread 1 buffer and the incoming thread 0 result.
- R4: In the same cycle as R3, mem_req pulses once if the majority of the request bits is 1. mem_we, mem_addr and mem_wdata are then the majority of the three copies.
- R5: vote_mismatch pulses with the vote outputs when any copy differs from the voted result in any field.
- R6: vote_dest_split pulses with the vote outputs when all three destination indices are pairwise different.
- R7: Both buffers are emptied and zeroed by a vote. A thread 0 result that arrives with no new buffered copies is therefore voted against two zero copies.
- R8: A second result for thread 1 or 2 before a vote raises buf_overrun for one cycle in the next cycle. The newer result replaces the older one.
- R9: A result tagged 3 is ignored. It causes no output pulse and leaves both buffers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Result present this cycle |
| in_tid | input | 2 | Thread tag of the result (0, 1, 2; 3 is ignored) |
| in_rf_we | input | 1 | Result writes the register file |
| in_rd | input | RD_W | Destination register index |
| in_data | input | DATA_W | Result data or store data |
| in_mem_req | input | 1 | Result is a memory access |
| in_mem_we | input | 1 | Memory access is a store |
| in_mem_addr | input | ADDR_W | Memory address |
| rf_we | output | 1 | Voted register write strobe |
| rf_addr | output | RD_W | Voted destination index |
| rf_data | output | DATA_W | Voted write data |
| mem_req | output | 1 | Single voted memory request |
| mem_we | output | 1 | Voted store flag |
| mem_addr | output | ADDR_W | Voted memory address |
| mem_wdata | output | DATA_W | Voted store data |
| vote_mismatch | output | 1 | Some copy disagreed with the vote |
| vote_dest_split | output | 1 | All three destinations differ |
| buf_overrun | output | 1 | A thread overwrote its unvoted buffer |

## Verification
The vote is swept over a grid of operand seeds and corruption patterns:
- all copies equal;
- only thread 2 corrupted;
- only thread 1 corrupted;
- only thread 0 corrupted;
- all three copies different.

The single-fault patterns show that each copy can be outvoted. The equal case shows that mismatch stays quiet. The all-different case separates dest_split from a plain mismatch.

Seeds alternate between register writes, loads and stores, so the memory port is tried for each request and store combination. Separate sequences cover four cases:
- a vote with emptied buffers;
- a thread that writes its buffer twice;
- an ignored tag 3 placed between real results;
- quiet outputs after the earlier threads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NTHR = 3;

    typedef enum logic [1:0] {
        TID_LAST  = 2'd0,
        TID_MID   = 2'd1,
        TID_FIRST = 2'd2,
        TID_NONE  = 2'd3
    } tid_e;
endpackage

// File: rtl/tmr_res_buf.sv
module tmr_res_buf #(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             clr,
    input  logic [PAY_W-1:0] wpay,
    output logic             vld,
    output logic [PAY_W-1:0] pay,
    output logic             overrun
);
    typedef struct packed {
        logic             vld;
        logic [PAY_W-1:0] pay;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.vld = 1'b1;
            st_d.pay = wpay;
        end else if (clr) begin
            st_d.vld = 1'b0;
            st_d.pay = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld     = st_q.vld;
    assign pay     = st_q.pay;
    assign overrun = wr && st_q.vld;
endmodule

// File: rtl/tmr_maj_vote.sv
module tmr_maj_vote #(
    parameter int PAY_W  = 8,
    parameter int RD_LSB = 0,
    parameter int RD_W   = 1
) (
    input  logic [PAY_W-1:0] c0,
    input  logic [PAY_W-1:0] c1,
    input  logic [PAY_W-1:0] c2,
    output logic [PAY_W-1:0] maj,
    output logic             mismatch,
    output logic             dest_split
);
    logic [RD_W-1:0] r0, r1, r2;

    always_comb begin
        maj        = (c0 & c1) | (c0 & c2) | (c1 & c2);
        mismatch   = (c0 != maj) || (c1 != maj) || (c2 != maj);
        r0         = c0[RD_LSB +: RD_W];
        r1         = c1[RD_LSB +: RD_W];
        r2         = c2[RD_LSB +: RD_W];
        dest_split = (r0 != r1) && (r0 != r2) && (r1 != r2);
    end
endmodule

// File: rtl/tmr_wb_voter.sv
module tmr_wb_voter #(
    parameter int DATA_W = 32,
    parameter int RD_W   = 5,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_tid,
    input  logic              in_rf_we,
    input  logic [RD_W-1:0]   in_rd,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_mem_req,
    input  logic              in_mem_we,
    input  logic [ADDR_W-1:0] in_mem_addr,
    output logic              rf_we,
    output logic [RD_W-1:0]   rf_addr,
    output logic [DATA_W-1:0] rf_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              vote_mismatch,
    output logic              vote_dest_split,
    output logic              buf_overrun
);
    import tmr_pkg::*;

    // payload layout, LSB first: address, store flag, request flag, data, index, write enable
    localparam int MWE_POS  = ADDR_W;
    localparam int MREQ_POS = ADDR_W + 1;
    localparam int DATA_LSB = ADDR_W + 2;
    localparam int RD_LSB   = DATA_LSB + DATA_W;
    localparam int WE_POS   = RD_LSB + RD_W;
    localparam int PAY_W    = WE_POS + 1;

    typedef struct packed {
        logic              rf_we;
        logic [RD_W-1:0]   rd;
        logic [DATA_W-1:0] data;
        logic              mem_req;
        logic              mem_we;
        logic [ADDR_W-1:0] maddr;
        logic              mism;
        logic              split;
        logic              ovr;
    } out_t;

    logic [PAY_W-1:0] in_pay;
    logic [PAY_W-1:0] copy [NTHR];
    logic [NTHR-1:0]  buf_vld;
    logic [NTHR-1:0]  buf_ovr;
    logic             vote_now;
    logic [PAY_W-1:0] maj;
    logic             mism, split;
    out_t             out_d, out_q;

    assign in_pay   = {in_rf_we, in_rd, in_data, in_mem_req, in_mem_we, in_mem_addr};
    assign vote_now = in_valid && (tid_e'(in_tid) == TID_LAST);
    assign copy[0]    = in_pay;
    assign buf_vld[0] = 1'b0;
    assign buf_ovr[0] = 1'b0;

    for (genvar g = 1; g < NTHR; g++) begin : g_buf
        logic wr_g;
        assign wr_g = in_valid && (in_tid == 2'(g));
        tmr_res_buf #(.PAY_W(PAY_W)) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (wr_g),
            .clr     (vote_now),
            .wpay    (in_pay),
            .vld     (buf_vld[g]),
            .pay     (copy[g]),
            .overrun (buf_ovr[g])
        );
    end

    tmr_maj_vote #(.PAY_W(PAY_W), .RD_LSB(RD_LSB), .RD_W(RD_W)) u_vote (
        .c0         (copy[0]),
        .c1         (copy[1]),
        .c2         (copy[2]),
        .maj        (maj),
        .mismatch   (mism),
        .dest_split (split)
    );

    always_comb begin
        out_d     = '0;
        out_d.ovr = |buf_ovr;
        if (vote_now) begin
            out_d.rf_we   = maj[WE_POS];
            out_d.rd      = maj[RD_LSB +: RD_W];
            out_d.data    = maj[DATA_LSB +: DATA_W];
            out_d.mem_req = maj[MREQ_POS];
            out_d.mem_we  = maj[MREQ_POS] && maj[MWE_POS];
            out_d.maddr   = maj[ADDR_W-1:0];
            out_d.mism    = mism;
            out_d.split   = split;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rf_we           = out_q.rf_we;
    assign rf_addr         = out_q.rd;
    assign rf_data         = out_q.data;
    assign mem_req         = out_q.mem_req;
    assign mem_we          = out_q.mem_we;
    assign mem_addr        = out_q.maddr;
    assign mem_wdata       = out_q.data;
    assign vote_mismatch   = out_q.mism;
    assign vote_dest_split = out_q.split;
    assign buf_overrun     = out_q.ovr;
endmodule

// File: rtl/tmr_wb_voter_chk.sv
module tmr_wb_voter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [1:0] in_tid,
    input logic       rf_we,
    input logic       mem_req,
    input logic       vote_mismatch,
    input logic       vote_dest_split,
    input logic       buf_overrun
);
    // R3
    rf_we_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(in_valid && in_tid == 2'd0));

    // R4
    mem_req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(in_valid && in_tid == 2'd0));

    // R6
    split_is_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vote_dest_split |-> vote_mismatch);

    // R8
    overrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_overrun |-> $past(in_valid && (in_tid == 2'd1 || in_tid == 2'd2)));

    // R5
    mismatch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vote_mismatch |-> $past(in_valid && in_tid == 2'd0));
endmodule

bind tmr_wb_voter tmr_wb_voter_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_tid          (in_tid),
    .rf_we           (rf_we),
    .mem_req         (mem_req),
    .vote_mismatch   (vote_mismatch),
    .vote_dest_split (vote_dest_split),
    .buf_overrun     (buf_overrun)
);

// File: tb/tmr_wb_voter_tb.sv
module tmr_wb_voter_tb;
    localparam int DW = 32;
    localparam int RW = 5;
    localparam int AW = 32;

    typedef struct packed {
        logic          we;
        logic [RW-1:0] rd;
        logic [DW-1:0] data;
        logic          mreq;
        logic          mwe;
        logic [AW-1:0] addr;
    } pay_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] in_tid = 2'd0;
    logic in_rf_we = 1'b0, in_mem_req = 1'b0, in_mem_we = 1'b0;
    logic [RW-1:0] in_rd = '0;
    logic [DW-1:0] in_data = '0;
    logic [AW-1:0] in_mem_addr = '0;
    logic rf_we, mem_req, mem_we, vote_mismatch, vote_dest_split, buf_overrun;
    logic [RW-1:0] rf_addr;
    logic [DW-1:0] rf_data, mem_wdata;
    logic [AW-1:0] mem_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_wb_voter u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tid(in_tid),
        .in_rf_we(in_rf_we), .in_rd(in_rd), .in_data(in_data),
        .in_mem_req(in_mem_req), .in_mem_we(in_mem_we), .in_mem_addr(in_mem_addr),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .vote_mismatch(vote_mismatch), .vote_dest_split(vote_dest_split),
        .buf_overrun(buf_overrun)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one result on the falling edge
    task automatic send(input logic [1:0] tid, input pay_t p);
        @(negedge clk);
        in_valid    = 1'b1;
        in_tid      = tid;
        in_rf_we    = p.we;
        in_rd       = p.rd;
        in_data     = p.data;
        in_mem_req  = p.mreq;
        in_mem_we   = p.mwe;
        in_mem_addr = p.addr;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic pay_t maj3(input pay_t a, input pay_t b, input pay_t c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // outputs reflect the vote at the falling edge after the thread 0 result
    task automatic check_vote(input string tag, input pay_t a, input pay_t b, input pay_t c);
        pay_t m;
        logic exp_mism, exp_split;
        m = maj3(a, b, c);
        exp_mism  = (a != m) || (b != m) || (c != m);
        exp_split = (a.rd != b.rd) && (a.rd != c.rd) && (b.rd != c.rd);
        chk({"R3 rf_we ", tag}, rf_we, m.we);
        chk({"R3 rf_addr ", tag}, rf_addr, m.rd);
        chk({"R3 rf_data ", tag}, rf_data, m.data);
        chk({"R4 mem_req ", tag}, mem_req, m.mreq);
        if (m.mreq) begin
            chk({"R4 mem_we ", tag}, mem_we, m.mwe);
            chk({"R4 mem_addr ", tag}, mem_addr, m.addr);
            chk({"R4 mem_wdata ", tag}, mem_wdata, m.data);
        end
        chk({"R5 mismatch ", tag}, vote_mismatch, exp_mism);
        chk({"R6 dest_split ", tag}, vote_dest_split, exp_split);
    endtask

    // full triple: thread 2, thread 1, thread 0, then observe
    task automatic triple(input string tag, input pay_t p2, input pay_t p1, input pay_t p0);
        send(2'd2, p2);
        send(2'd1, p1);
        chk({"R2 no write after t2 ", tag}, {rf_we, mem_req}, 2'b00);
        send(2'd0, p0);
        chk({"R2 no write after t1 ", tag}, {rf_we, mem_req}, 2'b00);
        idle();
        check_vote(tag, p2, p1, p0);
        @(negedge clk);
        chk({"R3 one-cycle pulse ", tag}, {rf_we, mem_req}, 2'b00);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        pay_t base, p0, p1, p2, q;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {rf_we, mem_req, vote_mismatch, vote_dest_split, buf_overrun}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {rf_we, mem_req, vote_mismatch, vote_dest_split, buf_overrun}, 5'b0);

        // sweep: seeds x corruption patterns
        for (int i = 0; i < 12; i++) begin
            base.we   = ~i[0];
            base.rd   = RW'(i * 7 + 3);
            base.data = DW'(32'h9E37_79B9 * (i + 1));
            base.mreq = i[0];
            base.mwe  = i[1];
            base.addr = AW'(32'h1000 + i * 32'h44);
            for (int m = 0; m < 5; m++) begin
                p0 = base; p1 = base; p2 = base;
                case (m)
                    1: begin p2.data = p2.data ^ 32'h0F0; p2.rd = p2.rd ^ 5'd1; p2.we = ~p2.we; end
                    2: begin p1.addr = p1.addr ^ 32'h8; p1.mreq = ~p1.mreq; p1.data = p1.data ^ 32'h1; end
                    3: begin p0.data = ~p0.data; p0.mwe = ~p0.mwe; p0.rd = p0.rd ^ 5'd4; end
                    4: begin
                        p1.rd = p1.rd ^ 5'd1; p2.rd = p2.rd ^ 5'd2;
                        p1.data = p1.data ^ 32'hFF00; p2.data = p2.data ^ 32'h00FF;
                    end
                    default: ;
                endcase
                triple($sformatf("seed%0d mode%0d", i, m), p2, p1, p0);
            end
        end

        // R7: vote with emptied buffers sees zero copies
        q = '{we:1'b1, rd:5'd9, data:32'hDEAD_BEEF, mreq:1'b1, mwe:1'b1, addr:32'h2000};
        send(2'd0, q);
        idle();
        check_vote("R7 emptied buffers", '0, '0, q);
        chk("R7 no write from lone t0", {rf_we, mem_req}, 2'b00);
        chk("R7 mismatch on lone t0", vote_mismatch, 1'b1);

        // R8: double write into thread 2 buffer
        p0 = '{we:1'b1, rd:5'd17, data:32'h1234_5678, mreq:1'b0, mwe:1'b0, addr:32'h0};
        p1 = p0; p1.data = 32'hAAAA_5555; p1.rd = 5'd3;
        send(2'd2, p1);
        send(2'd2, p0);
        chk("R8 no overrun on first write", buf_overrun, 1'b0);
        send(2'd1, p0);
        chk("R8 overrun pulse", buf_overrun, 1'b1);
        send(2'd0, p0);
        chk("R8 overrun one cycle", buf_overrun, 1'b0);
        idle();
        check_vote("R8 newest kept", p0, p0, p0);

        // R9: tag 3 is ignored
        p2 = '{we:1'b1, rd:5'd30, data:32'h0BAD_F00D, mreq:1'b1, mwe:1'b0, addr:32'h3C};
        q  = '{we:1'b1, rd:5'd1, data:32'hFFFF_FFFF, mreq:1'b1, mwe:1'b1, addr:32'hFFFC};
        send(2'd2, p2);
        send(2'd1, p2);
        send(2'd3, q);
        send(2'd0, p2);
        chk("R9 no output from tag 3", {rf_we, mem_req, buf_overrun}, 3'b000);
        idle();
        check_vote("R9 buffers untouched", p2, p2, p2);
        chk("R9 no mismatch", vote_mismatch, 1'b0);

        // R1: reset mid-stream clears buffers
        send(2'd2, q);
        send(2'd1, q);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears outputs", {rf_we, mem_req, vote_mismatch, buf_overrun}, 4'b0);
        rst_n = 1'b1;
        send(2'd0, p0);
        idle();
        check_vote("R1 buffers empty after reset", '0, '0, p0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule